// File: doc/BRIEF.md
# Dual-Channel Indirect Configuration Register Port

This block is the host-facing register file of a two-channel disk controller. Instead of mapping every configuration register into host address space, it exposes four small offsets. A pointer byte names a channel and a register index, and a 16-bit data window then reads or writes that register in the channel's bank of seven. An optional auto-advance mode moves the index forward after each data access, so software can stream a whole bank through the window with a single pointer write.

The same four offsets also hold a write-only test/mode register that shares its offset with a read-only status byte, and an interrupt register that combines per-channel mask bits with live interrupt status. The decoded per-channel fields (command and control block base addresses, general mode bits, read-ahead setup and timing bytes) leave the block as plain outputs for the rest of the controller. The host interface is a single-cycle strobe bus: `host_wr` or `host_rd` is held for one clock with `host_addr`. Read data is combinational from the current state, and the side effects of a read take effect at the clock edge that ends it. When both strobes are high, the cycle counts as one write.

Top module: `chan_cfg_port`

## Requirements
- R1: After reset, channel 0 holds command base 0x01F0 and control base 0x03F6, and channel 1 holds 0x0170 and 0x0376. Both channels reset their general byte to 0x01 (I/O enable set), their read-ahead fields to 0, their data timing to 0xF5 and their command timing to 0xDE. Interrupt masks and the test register reset to 0.
- R2: A write to offset 1 loads the pointer: bit 7 = auto-advance, bit 3 = channel, bits 2..0 = index. A write to offset 0 updates only the register chosen by that channel and index, and the change shows on the outputs in the cycle after the write.
- R3: A read of offset 0 returns the chosen register: index 0 = command base, 1 = general byte, 2 = read-ahead count bits 7..0, 3 = read-ahead control, 4 = control base, 5 = data timing, 6 = command timing. Byte-wide registers read with the upper byte zero.
- R4: With auto-advance set, every data-window read or write moves the index forward by one, wrapping from 6 (or 7) to 0, and leaves the channel bit unchanged. With auto-advance clear, the index does not move.
- R5: Index 7 reads as 0, and a write to it changes no register of either channel.
- R6: General byte decode, per channel: bit 7 = DMA enable, bit 6 = drive reset, bit 5 = ready-handshake enable, bit 4 = 8-bit data port, bit 3 = active-low interrupt, bit 2 = power-save, bit 1 = bus-master mode, bit 0 = I/O enable.
- R7: Read-ahead control (index 3) uses bit 7 = enable, bit 4 = mode-4 timing and bits 1..0 = count bits 9..8. Together with index 2 it forms a 10-bit count output.
- R8: Writing index 3 with bit 6 set raises the FIFO-clear output of the selected channel only, for exactly one cycle. Bit 6 always reads back as 0.
- R9: A write to offset 2 with bit 7 set loads compatibility mode (bit 1) and test mode (bit 0). A write to offset 2 with bit 7 clear is ignored.
- R10: A read of offset 2 returns bit 1 = channel-0 bus-master interrupt and bit 0 = channel-0 drive interrupt, with all other bits zero.
- R11: Offset 3 reads as {legacy header present (bit 4), channel-1 bus-master interrupt (bit 3), channel-1 drive interrupt (bit 2), channel-1 mask (bit 1), channel-0 mask (bit 0)}. A write loads only the two mask bits.
- R12: Each channel's interrupt output is (drive interrupt OR bus-master interrupt) AND NOT its mask bit.
- R13: A read of offset 1 returns the full pointer byte as last written (reset value 0x50).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| drv_irq_i | input | 2 | Per-channel drive interrupt status |
| bm_irq_i | input | 2 | Per-channel bus-master interrupt status |
| legacy_hdr_i | input | 1 | Legacy header present |
| cmd_base_o | output | 2x16 | Command block base address per channel |
| ctl_base_o | output | 2x16 | Control block base address per channel |
| dma_en_o | output | 2 | DMA enable |
| drv_reset_o | output | 2 | Drive reset request |
| iordy_en_o | output | 2 | Ready handshake enable |
| narrow_o | output | 2 | 8-bit data port select |
| irq_low_o | output | 2 | Active-low interrupt polarity |
| pwr_save_o | output | 2 | Power-save enable |
| bm_mode_o | output | 2 | Bus-master mode |
| io_en_o | output | 2 | I/O port enable |
| ra_en_o | output | 2 | Read-ahead enable |
| mode4_o | output | 2 | Mode-4 timing enable |
| ra_count_o | output | 2x10 | Read-ahead count |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse |
| data_tmg_o | output | 2x8 | Data port timing byte |
| cmd_tmg_o | output | 2x8 | Command port timing byte |
| compat_mode_o | output | 1 | Compatibility mode from test register |
| test_mode_o | output | 1 | Test mode from test register |
| irq_o | output | 2 | Gated per-channel interrupt |

## Verification
On every cycle, the assertions check these pointer and register rules: the index wraps after 6 and stands still when auto-advance is off, a data access leaves the channel bit unchanged, and a write to index 7 leaves the bank untouched. They also check that a FIFO-clear pulse always traces back to a qualifying write, that a test write with bit 7 clear is dropped, and that mask writes land. Only the bench scenarios can show the reset contents and the read-back layouts of each offset. The same holds for streaming a whole bank through auto-advance, for isolation between the two channels, and for the combined interrupt outputs under different status and mask patterns.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int NCH    = 2;
    localparam int CH_W   = 1;
    localparam int IDX_W  = 3;
    localparam int AW     = 16;
    localparam int DW     = 16;
    localparam int BW     = 8;
    localparam int RA_W   = 10;
    localparam int RAH_W  = RA_W - BW;
    localparam int TMG_W  = 8;

    localparam logic [IDX_W-1:0] IX_CMD   = 3'd0;
    localparam logic [IDX_W-1:0] IX_GEN   = 3'd1;
    localparam logic [IDX_W-1:0] IX_RALO  = 3'd2;
    localparam logic [IDX_W-1:0] IX_RACTL = 3'd3;
    localparam logic [IDX_W-1:0] IX_CTL   = 3'd4;
    localparam logic [IDX_W-1:0] IX_DTMG  = 3'd5;
    localparam logic [IDX_W-1:0] IX_CTMG  = 3'd6;
    localparam logic [IDX_W-1:0] IX_LAST  = 3'd6;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_PTR  = 2'd1;
    localparam logic [1:0] OFS_TEST = 2'd2;
    localparam logic [1:0] OFS_IRQ  = 2'd3;

    localparam logic [BW-1:0] PTR_RST = 8'h50;

    typedef struct packed {
        logic [AW-1:0]    cmd_base;
        logic [AW-1:0]    ctl_base;
        logic [BW-1:0]    gen;
        logic [BW-1:0]    ra_lo;
        logic             ra_en;
        logic             mode4;
        logic [RAH_W-1:0] ra_hi;
        logic [TMG_W-1:0] dtmg;
        logic [TMG_W-1:0] ctmg;
    } chan_cfg_t;

    function automatic chan_cfg_t cfg_reset(input int ch);
        chan_cfg_t r;
        r.cmd_base = (ch != 0) ? 16'h0170 : 16'h01F0;
        r.ctl_base = (ch != 0) ? 16'h0376 : 16'h03F6;
        r.gen      = 8'h01;
        r.ra_lo    = '0;
        r.ra_en    = 1'b0;
        r.mode4    = 1'b0;
        r.ra_hi    = '0;
        r.dtmg     = 8'hF5;
        r.ctmg     = 8'hDE;
        return r;
    endfunction
endpackage

// File: rtl/ccp_pointer.sv
module ccp_pointer
    import ccp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic [BW-1:0]    wbyte,
    input  logic             data_acc,
    output logic [CH_W-1:0]  chan_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [BW-1:0]    ptr_byte_o
);
    typedef struct packed {
        logic             adv;
        logic [2:0]       misc;
        logic [CH_W-1:0]  chan;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr) begin
            ptr_d = ptr_t'(wbyte);
        end else if (data_acc && ptr_q.adv) begin
            ptr_d.idx = (ptr_q.idx >= IX_LAST) ? '0 : ptr_q.idx + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= ptr_t'(PTR_RST);
        else        ptr_q <= ptr_d;
    end

    assign chan_o     = ptr_q.chan;
    assign idx_o      = ptr_q.idx;
    assign ptr_byte_o = ptr_q;

    assert_idx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr && ptr_q.adv && ptr_q.idx == IX_LAST) |=> (ptr_q.idx == '0));
    assert_chan_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr) |=> $stable(ptr_q.chan));
    assert_no_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_wr && !ptr_q.adv) |=> $stable(ptr_q.idx));
endmodule

// File: rtl/ccp_bank.sv
module ccp_bank
    import ccp_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output chan_cfg_t        cfg_o,
    output logic             fifo_clr_o
);
    typedef struct packed {
        chan_cfg_t cfg;
        logic      fifo;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.fifo = 1'b0;
        if (wr_en) begin
            case (idx)
                IX_CMD:   bank_d.cfg.cmd_base = wdata;
                IX_GEN:   bank_d.cfg.gen      = wdata[BW-1:0];
                IX_RALO:  bank_d.cfg.ra_lo    = wdata[BW-1:0];
                IX_RACTL: begin
                    bank_d.cfg.ra_en = wdata[7];
                    bank_d.fifo      = wdata[6];
                    bank_d.cfg.mode4 = wdata[4];
                    bank_d.cfg.ra_hi = wdata[RAH_W-1:0];
                end
                IX_CTL:   bank_d.cfg.ctl_base = wdata;
                IX_DTMG:  bank_d.cfg.dtmg     = wdata[TMG_W-1:0];
                IX_CTMG:  bank_d.cfg.ctmg     = wdata[TMG_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '{cfg: cfg_reset(CH), fifo: 1'b0};
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (idx)
            IX_CMD:   rdata = bank_q.cfg.cmd_base;
            IX_GEN:   rdata = {8'h00, bank_q.cfg.gen};
            IX_RALO:  rdata = {8'h00, bank_q.cfg.ra_lo};
            IX_RACTL: rdata = {8'h00, bank_q.cfg.ra_en, 2'b00, bank_q.cfg.mode4,
                               2'b00, bank_q.cfg.ra_hi};
            IX_CTL:   rdata = bank_q.cfg.ctl_base;
            IX_DTMG:  rdata = {8'h00, bank_q.cfg.dtmg};
            IX_CTMG:  rdata = {8'h00, bank_q.cfg.ctmg};
            default:  rdata = '0;
        endcase
    end

    assign cfg_o      = bank_q.cfg;
    assign fifo_clr_o = bank_q.fifo;

    assert_idx7_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 3'd7) |=> $stable(bank_q.cfg));
    assert_fifo_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr_o |-> $past(wr_en && idx == IX_RACTL && wdata[6]));
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
    import ccp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_wr,
    input  logic           mask_wr,
    input  logic [BW-1:0]  wbyte,
    input  logic [NCH-1:0] drv_irq,
    input  logic [NCH-1:0] bm_irq,
    input  logic           legacy_hdr,
    output logic [BW-1:0]  status_byte,
    output logic [BW-1:0]  irqreg_byte,
    output logic           compat_o,
    output logic           testm_o,
    output logic [NCH-1:0] irq_o
);
    typedef struct packed {
        logic           compat;
        logic           testm;
        logic [NCH-1:0] mask;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (test_wr && wbyte[7]) begin
            ctrl_d.compat = wbyte[1];
            ctrl_d.testm  = wbyte[0];
        end
        if (mask_wr) ctrl_d.mask = wbyte[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_irq
        assign irq_o[c] = (drv_irq[c] | bm_irq[c]) & ~ctrl_q.mask[c];
    end

    assign status_byte = {6'b0, bm_irq[0], drv_irq[0]};
    assign irqreg_byte = {3'b0, legacy_hdr, bm_irq[1], drv_irq[1], ctrl_q.mask};
    assign compat_o    = ctrl_q.compat;
    assign testm_o     = ctrl_q.testm;

    assert_test_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_wr && !wbyte[7]) |=> ($stable(ctrl_q.compat) && $stable(ctrl_q.testm)));
    assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (ctrl_q.mask == $past(wbyte[NCH-1:0])));
    assert_irq_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_irq | bm_irq) == '0) |-> (irq_o == '0));
endmodule

// File: rtl/chan_cfg_port.sv
module chan_cfg_port
    import ccp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [1:0]                 host_addr,
    input  logic [DW-1:0]              host_wdata,
    output logic [DW-1:0]              host_rdata,
    input  logic [NCH-1:0]             drv_irq_i,
    input  logic [NCH-1:0]             bm_irq_i,
    input  logic                       legacy_hdr_i,
    output logic [NCH-1:0][AW-1:0]     cmd_base_o,
    output logic [NCH-1:0][AW-1:0]     ctl_base_o,
    output logic [NCH-1:0]             dma_en_o,
    output logic [NCH-1:0]             drv_reset_o,
    output logic [NCH-1:0]             iordy_en_o,
    output logic [NCH-1:0]             narrow_o,
    output logic [NCH-1:0]             irq_low_o,
    output logic [NCH-1:0]             pwr_save_o,
    output logic [NCH-1:0]             bm_mode_o,
    output logic [NCH-1:0]             io_en_o,
    output logic [NCH-1:0]             ra_en_o,
    output logic [NCH-1:0]             mode4_o,
    output logic [NCH-1:0][RA_W-1:0]   ra_count_o,
    output logic [NCH-1:0]             fifo_clr_o,
    output logic [NCH-1:0][TMG_W-1:0]  data_tmg_o,
    output logic [NCH-1:0][TMG_W-1:0]  cmd_tmg_o,
    output logic                       compat_mode_o,
    output logic                       test_mode_o,
    output logic [NCH-1:0]             irq_o
);
    logic                   data_acc;
    logic                   ptr_wr;
    logic [CH_W-1:0]        chan;
    logic [IDX_W-1:0]       idx;
    logic [BW-1:0]          ptr_byte;
    logic [BW-1:0]          status_byte;
    logic [BW-1:0]          irqreg_byte;
    logic [NCH-1:0][DW-1:0] bank_rd;
    chan_cfg_t              cfg [NCH];

    assign data_acc = (host_wr || host_rd) && (host_addr == OFS_DATA);
    assign ptr_wr   = host_wr && (host_addr == OFS_PTR);

    ccp_pointer u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_wr     (ptr_wr),
        .wbyte      (host_wdata[BW-1:0]),
        .data_acc   (data_acc),
        .chan_o     (chan),
        .idx_o      (idx),
        .ptr_byte_o (ptr_byte)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_bank
        logic bank_wr;
        assign bank_wr = host_wr && (host_addr == OFS_DATA) && (chan == CH_W'(g));

        ccp_bank #(.CH(g)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bank_wr),
            .idx        (idx),
            .wdata      (host_wdata),
            .rdata      (bank_rd[g]),
            .cfg_o      (cfg[g]),
            .fifo_clr_o (fifo_clr_o[g])
        );

        assign cmd_base_o[g]  = cfg[g].cmd_base;
        assign ctl_base_o[g]  = cfg[g].ctl_base;
        assign dma_en_o[g]    = cfg[g].gen[7];
        assign drv_reset_o[g] = cfg[g].gen[6];
        assign iordy_en_o[g]  = cfg[g].gen[5];
        assign narrow_o[g]    = cfg[g].gen[4];
        assign irq_low_o[g]   = cfg[g].gen[3];
        assign pwr_save_o[g]  = cfg[g].gen[2];
        assign bm_mode_o[g]   = cfg[g].gen[1];
        assign io_en_o[g]     = cfg[g].gen[0];
        assign ra_en_o[g]     = cfg[g].ra_en;
        assign mode4_o[g]     = cfg[g].mode4;
        assign ra_count_o[g]  = {cfg[g].ra_hi, cfg[g].ra_lo};
        assign data_tmg_o[g]  = cfg[g].dtmg;
        assign cmd_tmg_o[g]   = cfg[g].ctmg;
    end

    ccp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_wr     (host_wr && (host_addr == OFS_TEST)),
        .mask_wr     (host_wr && (host_addr == OFS_IRQ)),
        .wbyte       (host_wdata[BW-1:0]),
        .drv_irq     (drv_irq_i),
        .bm_irq      (bm_irq_i),
        .legacy_hdr  (legacy_hdr_i),
        .status_byte (status_byte),
        .irqreg_byte (irqreg_byte),
        .compat_o    (compat_mode_o),
        .testm_o     (test_mode_o),
        .irq_o       (irq_o)
    );

    always_comb begin
        case (host_addr)
            OFS_DATA: host_rdata = bank_rd[chan];
            OFS_PTR:  host_rdata = {8'h00, ptr_byte};
            OFS_TEST: host_rdata = {8'h00, status_byte};
            default:  host_rdata = {8'h00, irqreg_byte};
        endcase
    end

    assert_fifo_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_clr_o));
endmodule

// File: tb/sim_chan_cfg_port.sv
module sim_chan_cfg_port;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]        host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic [1:0]        drv_irq_i = '0, bm_irq_i = '0;
    logic              legacy_hdr_i = 1'b0;
    logic [1:0][15:0]  cmd_base_o, ctl_base_o;
    logic [1:0]        dma_en_o, drv_reset_o, iordy_en_o, narrow_o, irq_low_o;
    logic [1:0]        pwr_save_o, bm_mode_o, io_en_o, ra_en_o, mode4_o, fifo_clr_o;
    logic [1:0][9:0]   ra_count_o;
    logic [1:0][7:0]   data_tmg_o, cmd_tmg_o;
    logic              compat_mode_o, test_mode_o;
    logic [1:0]        irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    chan_cfg_port u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                check("monitor queue empty", 32'(host_rdata), 32'hFFFF_FFFF);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(host_rdata), 32'(e));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] snap_cmd, snap_ctl;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset outputs
        check("R1 cmd base ch0", 32'(cmd_base_o[0]), 32'h01F0);
        check("R1 cmd base ch1", 32'(cmd_base_o[1]), 32'h0170);
        check("R1 ctl base ch0", 32'(ctl_base_o[0]), 32'h03F6);
        check("R1 ctl base ch1", 32'(ctl_base_o[1]), 32'h0376);
        check("R1 io enable", 32'(io_en_o), 32'h3);
        check("R1 dma off", 32'(dma_en_o), 32'h0);
        check("R1 timings", 32'({data_tmg_o[0], cmd_tmg_o[1]}), 32'hF5DE);
        check("R1 test reg", 32'({compat_mode_o, test_mode_o}), 32'h0);
        rd_exp(2'd1, 16'h0050, "R13 pointer reset");

        // R3 R4 stream bank 0 with auto-advance, wrap from 6 to 0
        wr(2'd1, 16'h0080);
        rd_exp(2'd0, 16'h01F0, "R3 ch0 idx0");
        rd_exp(2'd0, 16'h0001, "R3 ch0 idx1");
        rd_exp(2'd0, 16'h0000, "R3 ch0 idx2");
        rd_exp(2'd0, 16'h0000, "R3 ch0 idx3");
        rd_exp(2'd0, 16'h03F6, "R3 ch0 idx4");
        rd_exp(2'd0, 16'h00F5, "R3 ch0 idx5");
        rd_exp(2'd0, 16'h00DE, "R3 ch0 idx6");
        rd_exp(2'd0, 16'h01F0, "R4 wrap to idx0");
        wr(2'd1, 16'h0088);
        rd_exp(2'd0, 16'h0170, "R3 ch1 idx0");
        rd_exp(2'd0, 16'h0001, "R3 ch1 idx1");
        rd_exp(2'd0, 16'h0000, "R3 ch1 idx2");
        rd_exp(2'd0, 16'h0000, "R3 ch1 idx3");
        rd_exp(2'd0, 16'h0376, "R3 ch1 idx4");
        rd_exp(2'd0, 16'h00F5, "R3 ch1 idx5");
        rd_exp(2'd0, 16'h00DE, "R3 ch1 idx6");

        // R2 write ch1 idx0, no auto-advance
        wr(2'd1, 16'h0008);
        wr(2'd0, 16'h1234);
        check("R2 ch1 cmd base", 32'(cmd_base_o[1]), 32'h1234);
        check("R2 ch0 untouched", 32'(cmd_base_o[0]), 32'h01F0);
        rd_exp(2'd0, 16'h1234, "R3 readback");
        rd_exp(2'd0, 16'h1234, "R4 no advance");
        rd_exp(2'd1, 16'h0008, "R13 pointer readback");

        // R6 R7 R8 stream writes into ch0 from idx1
        wr(2'd1, 16'h0081);
        wr(2'd0, 16'h00DB);
        check("R6 dma", 32'(dma_en_o), 32'h1);
        check("R6 reset", 32'(drv_reset_o), 32'h1);
        check("R6 iordy", 32'(iordy_en_o), 32'h0);
        check("R6 narrow", 32'(narrow_o), 32'h1);
        check("R6 irq low", 32'(irq_low_o), 32'h1);
        check("R6 pwr", 32'(pwr_save_o), 32'h0);
        check("R6 bm mode", 32'(bm_mode_o), 32'h1);
        check("R6 io en", 32'(io_en_o), 32'h3);
        wr(2'd0, 16'h0034);
        wr(2'd0, 16'h00D3);
        check("R8 fifo pulse", 32'(fifo_clr_o), 32'h1);
        check("R7 count", 32'(ra_count_o[0]), 32'h334);
        check("R7 enable", 32'(ra_en_o), 32'h1);
        check("R7 mode4", 32'(mode4_o), 32'h1);
        @(posedge clk); #1;
        check("R8 pulse ends", 32'(fifo_clr_o), 32'h0);
        wr(2'd0, 16'h03F4);
        wr(2'd0, 16'h0009);
        wr(2'd0, 16'h0000);
        check("R2 ctl base ch0", 32'(ctl_base_o[0]), 32'h03F4);
        check("R2 data tmg ch0", 32'(data_tmg_o[0]), 32'h09);
        check("R2 cmd tmg ch0", 32'(cmd_tmg_o[0]), 32'h00);
        check("R2 ch1 tmg kept", 32'(data_tmg_o[1]), 32'hF5);
        rd_exp(2'd1, 16'h0080, "R4 wrapped, channel kept");
        wr(2'd1, 16'h0003);
        rd_exp(2'd0, 16'h0093, "R8 clear bit reads 0");

        // R5 index 7
        snap_cmd = cmd_base_o[0]; snap_ctl = ctl_base_o[0];
        wr(2'd1, 16'h0007);
        wr(2'd0, 16'hFFFF);
        check("R5 cmd kept", 32'(cmd_base_o[0]), 32'(snap_cmd));
        check("R5 ctl kept", 32'(ctl_base_o[0]), 32'(snap_ctl));
        check("R5 gen kept", 32'({dma_en_o, io_en_o}), 32'h7);
        check("R5 ch1 kept", 32'(cmd_base_o[1]), 32'h1234);
        rd_exp(2'd0, 16'h0000, "R5 reads zero");
        wr(2'd1, 16'h0087);
        rd_exp(2'd0, 16'h0000, "R5 idx7 with advance");
        rd_exp(2'd1, 16'h0080, "R4 idx7 wraps");

        // R9 test register
        wr(2'd2, 16'h0003);
        check("R9 ignored without bit7", 32'({compat_mode_o, test_mode_o}), 32'h0);
        wr(2'd2, 16'h0083);
        check("R9 loaded", 32'({compat_mode_o, test_mode_o}), 32'h3);
        wr(2'd2, 16'h0082);
        check("R9 reload", 32'({compat_mode_o, test_mode_o}), 32'h2);

        // R10 R11 R12 status, mask, interrupt
        drv_irq_i = 2'b01; bm_irq_i = 2'b00;
        rd_exp(2'd2, 16'h0001, "R10 drive irq");
        check("R12 ch0 drive", 32'(irq_o), 32'h1);
        drv_irq_i = 2'b10; bm_irq_i = 2'b11; legacy_hdr_i = 1'b1;
        rd_exp(2'd2, 16'h0002, "R10 bm irq");
        wr(2'd3, 16'h00FE);
        rd_exp(2'd3, 16'h001E, "R11 layout");
        check("R12 ch1 masked", 32'(irq_o), 32'h1);
        wr(2'd3, 16'h0001);
        check("R12 ch0 masked", 32'(irq_o), 32'h2);
        drv_irq_i = 2'b00; bm_irq_i = 2'b00; legacy_hdr_i = 1'b0;
        rd_exp(2'd3, 16'h0001, "R11 mask only");
        check("R12 no source", 32'(irq_o), 32'h0);

        @(posedge clk); #1;
        check("monitor drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end
endmodule